// File: doc/BRIEF.md
# Framed Serial Transducer Link Slave

This block sits on the transducer side of a synchronous byte-serial link driven by a host processor. The host pulls an active-low frame-select line low to open a transfer and supplies its own serial clock. Data in both directions is captured on that clock's rising edge, most significant bit first, eight edges per byte. Before every byte the block flips its acknowledge line once. The host waits for that flip before it clocks the byte, so the block sets the pace of the transfer.

The first byte of a frame is taken as a function address and the second as a channel address. A channel number above the configured channel count is flagged as invalid, and zero addresses the whole module. Later bytes are handed to the transducer side on a byte-wide strobe. Each outgoing byte is taken from a transmit register that the transducer side fills, or is all zeros if that register was not filled. If the host lifts frame-select part way through a byte, the frame is reported as aborted. A falling edge on the trigger input while no frame is open is passed on as a one-cycle request, and the acknowledge line is held low for a configurable handshake time.

The host-side inputs pass through two-flop synchronizers and are edge-detected in the system clock domain. The system clock must run at least four times faster than the host clock.

Top module: `xdcr_frame_slave`

## Requirements
- R1: After reset the acknowledge output is high, the serial output is low, and none of the pulse outputs (address valid, receive valid, abort, trigger request) is asserted.
- R2: Received bits are sampled on rising edges of the host clock, most significant bit first. A byte is complete after eight rising edges.
- R3: The acknowledge output flips exactly once before each byte: once when frame-select is seen low, and once after each completed byte while frame-select stays low. It holds steady while a byte is being clocked.
- R4: Byte 0 of a frame appears on the function output and byte 1 on the channel output, with a one-cycle address-valid pulse. Every later byte appears on the receive-data output with a one-cycle receive-valid pulse. The two pulses never coincide.
- R5: The invalid-channel flag is set together with address valid when the channel byte is greater than NCHAN. It is clear for channel 0 and for 1..NCHAN, and it is cleared when a new frame opens.
- R6: The bits shifted out during a byte equal the transmit register value held at the acknowledge flip that opened the byte. Taking that value empties the register, so a byte with no new load shifts out all zeros.
- R7: If frame-select rises after 1 to 7 bits of a byte have been clocked, a one-cycle abort pulse is issued. The partial byte is discarded, the acknowledge output returns high, and it does not flip again in that frame.
- R8: If frame-select rises on the same host-clock edge as the eighth bit, the byte is delivered normally and no abort is reported.
- R9: When a frame ends, the acknowledge output returns high, and a new frame opens on the next time frame-select is seen low. This holds whether the frame ended normally or by abort.
- R10: A falling edge on the trigger input while no frame is open and no handshake is running produces a one-cycle trigger request and drives acknowledge low for exactly HS_CYCLES system clocks.
- R11: A trigger edge that arrives while a frame is open produces no request and does not disturb the acknowledge output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hclk_i | input | 1 | Host serial clock |
| hdin_i | input | 1 | Serial data from host |
| hsel_n_i | input | 1 | Active-low frame select |
| trig_n_i | input | 1 | Trigger input, falling-edge active |
| hdout_o | output | 1 | Serial data to host |
| ack_o | output | 1 | Byte pacing and trigger acknowledge |
| tx_load_i | input | 1 | Write strobe for the transmit register |
| tx_data_i | input | 8 | Transmit register value |
| func_o | output | 8 | Function address of the current frame |
| chan_o | output | 8 | Channel address of the current frame |
| addr_vld_o | output | 1 | Pulse: both address bytes captured |
| bad_chan_o | output | 1 | Channel address above NCHAN |
| rx_data_o | output | 8 | Received payload byte |
| rx_vld_o | output | 1 | Pulse: payload byte received |
| abort_o | output | 1 | Pulse: frame aborted in mid-byte |
| trig_req_o | output | 1 | Pulse: trigger accepted |

## Verification
Random frames of two to six bytes are mixed with random payload and random gaps in the transmit loads. This separates correct bit order and byte routing from shifted or swapped data, and it shows whether an unloaded byte really goes out as zeros. Directed channel values at 0, NCHAN, NCHAN+1 and 255 locate the boundary of the invalid-channel compare. Aborts after one and after seven bits, and a frame-select rise on the same edge as the eighth bit, tell an abort apart from a late but valid completion. Triggers sent while idle and while a frame is open show whether the frame gate and the exact handshake length are correct.

// File: rtl/xdcr_frame_slave.sv
module xdcr_frame_slave #(
  parameter int NCHAN     = 2,
  parameter int HS_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hclk_i,
  input  logic       hdin_i,
  input  logic       hsel_n_i,
  input  logic       trig_n_i,
  output logic       hdout_o,
  output logic       ack_o,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  output logic [7:0] func_o,
  output logic [7:0] chan_o,
  output logic       addr_vld_o,
  output logic       bad_chan_o,
  output logic [7:0] rx_data_o,
  output logic       rx_vld_o,
  output logic       abort_o,
  output logic       trig_req_o
);
  localparam int HSW = $clog2(HS_CYCLES + 1);
  localparam logic [7:0] MAXCH = 8'(NCHAN);

  logic [2:0] hck_q, din_q, trg_q;
  logic [1:0] sel_q;
  logic       in_frame;
  logic [2:0] bitcnt;
  logic [1:0] bidx;
  logic [7:0] txsh, rxsh, txreg;
  logic [HSW-1:0] hs_cnt;

  wire h_rise  = hck_q[1] & ~hck_q[2];
  wire t_fall  = ~trg_q[1] & trg_q[2];
  wire sel_hi  = sel_q[1];
  wire byte_done = in_frame & h_rise & (bitcnt == 3'd7);
  wire [7:0] rx_byte = {rxsh[6:0], din_q[1]};

  assign hdout_o = txsh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hck_q <= '0; din_q <= '0; trg_q <= '1; sel_q <= '1;
      in_frame <= 1'b0; bitcnt <= '0; bidx <= '0;
      txsh <= '0; rxsh <= '0; txreg <= '0; hs_cnt <= '0;
      ack_o <= 1'b1; func_o <= '0; chan_o <= '0; bad_chan_o <= 1'b0;
      rx_data_o <= '0; addr_vld_o <= 1'b0; rx_vld_o <= 1'b0;
      abort_o <= 1'b0; trig_req_o <= 1'b0;
    end else begin
      hck_q <= {hck_q[1:0], hclk_i};
      din_q <= {din_q[1:0], hdin_i};
      trg_q <= {trg_q[1:0], trig_n_i};
      sel_q <= {sel_q[0], hsel_n_i};
      addr_vld_o <= 1'b0; rx_vld_o <= 1'b0; abort_o <= 1'b0; trig_req_o <= 1'b0;

      if (hs_cnt != '0) begin
        hs_cnt <= hs_cnt - 1'b1;
        if (hs_cnt == HSW'(1)) ack_o <= 1'b1;
      end

      if (!in_frame) begin
        if (!sel_hi && hs_cnt == '0) begin
          in_frame <= 1'b1; ack_o <= ~ack_o;
          txsh <= txreg; txreg <= '0;
          bitcnt <= '0; bidx <= '0; bad_chan_o <= 1'b0;
        end else if (sel_hi && t_fall && hs_cnt == '0) begin
          ack_o <= 1'b0; hs_cnt <= HSW'(HS_CYCLES); trig_req_o <= 1'b1;
        end
      end else if (byte_done) begin
        rxsh <= rx_byte; bitcnt <= '0;
        case (bidx)
          2'd0: func_o <= rx_byte;
          2'd1: begin chan_o <= rx_byte; addr_vld_o <= 1'b1; bad_chan_o <= rx_byte > MAXCH; end
          default: begin rx_data_o <= rx_byte; rx_vld_o <= 1'b1; end
        endcase
        if (bidx != 2'd2) bidx <= bidx + 1'b1;
        if (sel_hi) begin
          in_frame <= 1'b0; ack_o <= 1'b1;
        end else begin
          ack_o <= ~ack_o; txsh <= txreg; txreg <= '0;
        end
      end else if (sel_hi) begin
        in_frame <= 1'b0; ack_o <= 1'b1;
        if (bitcnt != '0) abort_o <= 1'b1;
      end else if (h_rise) begin
        rxsh <= rx_byte; txsh <= {txsh[6:0], 1'b0}; bitcnt <= bitcnt + 1'b1;
      end

      if (tx_load_i) txreg <= tx_data_i;
    end
  end

  AST_ACK_STEADY_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && bitcnt != '0 && !h_rise && !sel_hi) |=> $stable(ack_o)); // R3
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_vld_o && rx_vld_o)); // R4
  AST_ABORT_RELEASES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (ack_o && !in_frame)); // R7
  AST_HS_HOLDS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cnt != '0) |-> !ack_o); // R10
  AST_TRIG_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req_o |-> !in_frame); // R11
endmodule

// File: tb/xdcr_frame_slave_test.sv
module xdcr_frame_slave_test;
  localparam int NCH = 2;
  localparam int HS  = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hclk = 1'b0, hdin = 1'b0, hsel_n = 1'b1, trig_n = 1'b1;
  logic tx_load = 1'b0;
  logic [7:0] tx_data = '0;
  logic hdout, ack, addr_vld, bad_chan, rx_vld, abort_p, trig_req;
  logic [7:0] func, chan, rx_data;

  always #10 clk = ~clk;

  xdcr_frame_slave #(.NCHAN(NCH), .HS_CYCLES(HS)) uut (
    .clk(clk), .rst_n(rst_n), .hclk_i(hclk), .hdin_i(hdin), .hsel_n_i(hsel_n),
    .trig_n_i(trig_n), .hdout_o(hdout), .ack_o(ack), .tx_load_i(tx_load),
    .tx_data_i(tx_data), .func_o(func), .chan_o(chan), .addr_vld_o(addr_vld),
    .bad_chan_o(bad_chan), .rx_data_o(rx_data), .rx_vld_o(rx_vld),
    .abort_o(abort_p), .trig_req_o(trig_req));

  int tests = 0, fails = 0;
  bit done = 0;
  int rx_n = 0, ab_n = 0, tr_n = 0, tog_n = 0, addr_n = 0;
  logic [7:0] rx_log [0:255];
  logic [7:0] m_func, m_chan;
  logic m_bad;
  logic ack_prev = 1'b1, seen_ack = 1'b1;
  logic [7:0] hb [0:15];
  logic [7:0] txv [0:15];
  bit txl [0:15];

  always @(negedge clk) begin
    if (addr_vld) begin m_func = func; m_chan = chan; m_bad = bad_chan; addr_n++; end
    if (rx_vld) begin rx_log[rx_n[7:0]] = rx_data; rx_n++; end
    if (abort_p) ab_n++;
    if (trig_req) tr_n++;
    if (rst_n && !hsel_n && ack !== ack_prev) tog_n++;
    ack_prev = ack;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [7:0] c);
    return c > 8'(NCH);
  endfunction

  task automatic wait_toggle(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      if (ack !== seen_ack) begin ok = 1; seen_ack = ack; break; end
      @(negedge clk);
    end
  endtask

  task automatic host_byte(input logic [7:0] d, input int nbits, input bit sel_last,
                           output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      hdin = d[7-i];
      repeat (6) @(negedge clk);
      got[7-i] = hdout;
      hclk = 1'b1;
      if (sel_last && i == nbits - 1) hsel_n = 1'b1;
      repeat (6) @(negedge clk);
      hclk = 1'b0;
    end
  endtask

  task automatic load_tx(input logic [7:0] v);
    tx_data = v; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic run_frame(input int n, input bit same_edge);
    int rx0, ab0, t0, a0;
    bit ok;
    logic [7:0] got;
    rx0 = rx_n; ab0 = ab_n; t0 = tog_n; a0 = addr_n;
    if (txl[0]) load_tx(txv[0]);
    seen_ack = 1'b1;
    hsel_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      wait_toggle(ok);
      chk("R3 ack flip before byte", 32'(ok), 32'd1);
      if (k + 1 < n && txl[k+1]) load_tx(txv[k+1]);
      host_byte(hb[k], 8, same_edge && k == n - 1, got);
      chk("R6 shifted-out byte", 32'(got), txl[k] ? 32'(txv[k]) : 32'd0);
    end
    repeat (4) @(negedge clk);
    hsel_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 flips per frame", 32'(tog_n - t0), same_edge ? 32'(n) : 32'(n + 1));
    chk("R9 ack high after frame", 32'(ack), 32'd1);
    chk("R8 no abort on whole bytes", 32'(ab_n - ab0), 32'd0);
    chk("R4 address pulse count", 32'(addr_n - a0), 32'd1);
    chk("R4 function byte", 32'(m_func), 32'(hb[0]));
    chk("R4 channel byte", 32'(m_chan), 32'(hb[1]));
    chk("R5 invalid channel flag", 32'(m_bad), 32'(exp_bad(hb[1])));
    chk("R2 payload count", 32'(rx_n - rx0), 32'(n - 2));
    for (int k = 2; k < n; k++)
      chk("R2 payload byte", 32'(rx_log[8'(rx0 + k - 2)]), 32'(hb[k]));
  endtask

  task automatic abort_frame(input int nbits);
    int rx0, ab0, t0;
    bit ok;
    logic [7:0] got;
    rx0 = rx_n; ab0 = ab_n; t0 = tog_n;
    seen_ack = 1'b1;
    hsel_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      wait_toggle(ok);
      host_byte(8'(k + 5), 8, 1'b0, got);
    end
    wait_toggle(ok);
    host_byte(8'hA5, nbits, 1'b0, got);
    repeat (4) @(negedge clk);
    hsel_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7 abort pulse", 32'(ab_n - ab0), 32'd1);
    chk("R7 partial byte dropped", 32'(rx_n - rx0), 32'd0);
    chk("R7 no flip after abort", 32'(tog_n - t0), 32'd3);
    chk("R9 ack high after abort", 32'(ack), 32'd1);
  endtask

  task automatic trigger_idle();
    int tr0, low;
    bit seen;
    tr0 = tr_n; low = 0; seen = 0;
    trig_n = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (trig_req) seen = 1;
    end
    while (ack === 1'b0 && low < 4 * HS) begin low++; @(negedge clk); end
    chk("R10 trigger request seen", 32'(seen), 32'd1);
    chk("R10 ack low length", 32'(low), 32'(HS));
    trig_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 single request pulse", 32'(tr_n - tr0), 32'd1);
  endtask

  initial begin
    bit ok;
    int tr0, t0;
    logic [7:0] got;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk("R1 ack after reset", 32'(ack), 32'd1);
    chk("R1 dout after reset", 32'(hdout), 32'd0);
    chk("R1 pulses after reset", 32'({addr_vld, rx_vld, abort_p, trig_req}), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    foreach (txl[i]) begin txl[i] = 0; txv[i] = '0; end
    hb[0] = 8'h80; hb[1] = 8'h00; hb[2] = 8'h3C;
    txl[0] = 1; txv[0] = 8'hC3; txl[2] = 1; txv[2] = 8'h81;
    run_frame(3, 0);
    hb[1] = 8'(NCH); run_frame(2, 0);
    hb[1] = 8'(NCH + 1); run_frame(2, 0);
    hb[1] = 8'hFF; hb[2] = 8'h5A; hb[3] = 8'h01; run_frame(4, 1);

    for (int f = 0; f < 16; f++) begin
      int n;
      n = 2 + int'($urandom % 5);
      for (int k = 0; k < n; k++) begin
        hb[k] = 8'($urandom);
        txv[k] = 8'($urandom);
        txl[k] = ($urandom % 4) != 0;
      end
      if (($urandom % 3) == 0) hb[1] = 8'($urandom % (NCH + 2));
      run_frame(n, ($urandom % 4) == 0);
    end

    foreach (txl[i]) txl[i] = 0;
    abort_frame(1);
    abort_frame(7);
    hb[0] = 8'h11; hb[1] = 8'h01; hb[2] = 8'hEE;
    run_frame(3, 0);

    trigger_idle();

    tr0 = tr_n; t0 = tog_n;
    seen_ack = 1'b1;
    hsel_n = 1'b0;
    wait_toggle(ok);
    trig_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R11 no request in frame", 32'(tr_n - tr0), 32'd0);
    chk("R11 ack unchanged in frame", 32'(tog_n - t0), 32'd1);
    host_byte(8'h22, 8, 1'b0, got);
    trig_n = 1'b1;
    wait_toggle(ok);
    host_byte(8'h01, 8, 1'b1, got);
    repeat (10) @(negedge clk);
    chk("R11 frame completes", 32'(m_chan), 32'h01);
    chk("R11 ack high after", 32'(ack), 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule